// File: doc/BRIEF.md
# Cache Maintenance Sweep Engine

This block carries out invalidate and push commands on a set-associative data cache, a set-associative instruction cache, or both at once. A command is an 8-bit word plus a base address. From these the block works out the address range: one 16-byte line, one 4 KiB or 8 KiB page, or the whole cache. It then steps through that range one line address per cycle. At each step it reads the indexed set of each selected cache through a lookup port and clears every valid way whose tag belongs to the range.

When the push flag is set, the dirty longwords of each data line being invalidated are written out before the line is cleared. Each write goes out through a ready/valid write-back port, one longword per accepted transfer. When the flag is clear, dirty data is dropped. Every accepted command also raises a one-cycle strobe that invalidates the fetch unit's line buffer. When the last set has been handled, `done` pulses.

The cache arrays and the memory behind the write-back port sit outside the block. The block reads tag, valid and dirty state combinationally at the index it drives, and it requests clears with a per-way mask that takes effect at the next clock edge.

Top module: `cache_maint_seq`

## Requirements
- R1: `cmdReady` is high only when the block is idle and `done` is low. A command is taken on a clock edge where `cmdValid` and `cmdReady` are both high. `cmdValid` is ignored at all other times. `lineBufInval` is high for exactly the one cycle after each accepted command.
- R2: Bit 6 of `cmdWord` selects the data cache and bit 7 selects the instruction cache; both may be set. A cache that is not selected is left unchanged. If neither bit is set, no line is touched and `done` is high in the cycle after acceptance.
- R3: A scope field (`cmdWord[4:3]`) of 1, or of 0, means line scope. The base address is aligned down to 16 bytes and one set is examined. `done` is high two cycles after acceptance when nothing is pushed.
- R4: A scope field of 2 means page scope. The base address is aligned down to 8192 bytes when `page8k` is high and to 4096 bytes otherwise. Every 16-byte line of that page is examined, one per cycle, so `done` comes 257 or 513 cycles after acceptance when nothing is pushed.
- R5: A scope field of 3 means whole-cache scope. Every valid way of every set of the selected caches is cleared, whatever its tag and whatever the base address.
- R6: For a line address A, the set index is A[IDXW+3:4] with IDXW = log2(SETS), and the tag is A[ADDR_W-1:IDXW+4]. In line and page scope, a way is cleared only if it is valid and its tag equals the tag of a line address in the range. Other ways in the same set keep their state.
- R7: With the push flag (`cmdWord[5]`) clear, no write-back is issued. All four dirty bits of every cleared data way are also cleared.
- R8: With the push flag set, each dirty longword k of each cleared data way goes out on `wbAddr` = {stored tag, set index, k, 2'b00} together with its data. Transfers are ordered by way and then by k, both ascending. Each one takes one cycle when `wbReady` is high. While `wbReady` is low, `wbAddr` and `wbData` hold steady.
- R9: `done` is a single-cycle pulse that comes one cycle after the clear request for the last set.
- R10: The instruction cache is never written back. Its matching ways are only invalidated, even when the push flag is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cmdValid | input | 1 | Command request |
| cmdReady | output | 1 | Block can take a command |
| cmdWord | input | 8 | Command: [7] instruction cache, [6] data cache, [5] push, [4:3] scope |
| baseAddr | input | ADDR_W | Base address of the command |
| page8k | input | 1 | Page size is 8192 bytes when high, 4096 when low |
| lkIdx | output | log2(SETS) | Set index presented to both caches |
| dTags | input | WAYS*TAGW | Data cache tags of the indexed set, way 0 lowest |
| dValid | input | WAYS | Data cache valid bits of the indexed set |
| dDirty | input | WAYS*4 | Data cache dirty bits, bit w*4+k for way w longword k |
| dRdWay | output | max(1,log2(WAYS)) | Way of the longword being pushed |
| dRdWord | output | 2 | Longword number being pushed |
| dRdData | input | 32 | Data of the selected longword |
| iTags | input | WAYS*TAGW | Instruction cache tags of the indexed set |
| iValid | input | WAYS | Instruction cache valid bits of the indexed set |
| clrEn | output | 1 | Clear request for the indexed set |
| dClrWays | output | WAYS | Data ways to invalidate and mark clean |
| iClrWays | output | WAYS | Instruction ways to invalidate |
| wbValid | output | 1 | Write-back request |
| wbReady | input | 1 | Write-back accepted |
| wbAddr | output | ADDR_W | Write-back byte address |
| wbData | output | 32 | Write-back longword |
| lineBufInval | output | 1 | Invalidate the fetch line buffer |
| done | output | 1 | Command finished |

## Verification
The bench builds the block with SETS=16 and WAYS=2. With only 16 sets, a 4 KiB page walk visits every set sixteen times under different tags, so a line just outside the page shares a set with a line inside it and must survive. Two ways let one set hold a hit beside a miss. The whole-cache sweep takes only sixteen steps, which leaves room for exact cycle counts, ordered write-back addresses built from stored tags, and a busy-period command that must be ignored.

// File: rtl/mnt_pkg.sv
package mnt_pkg;

  localparam int CMD_W     = 8;
  localparam int SEL_D_BIT = 6;
  localparam int SEL_I_BIT = 7;
  localparam int PUSH_BIT  = 5;
  localparam int SCOPE_LO  = 3;
  localparam int LINE_WORDS = 4;

  typedef enum logic [1:0] {
    SCOPE_LINE0 = 2'd0,
    SCOPE_LINE  = 2'd1,
    SCOPE_PAGE  = 2'd2,
    SCOPE_ALL   = 2'd3
  } scope_t;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LOOK = 2'd1,
    ST_PUSH = 2'd2
  } seqState_t;

  // strobes from control into the datapath
  typedef struct packed {
    logic load;
    logic advance;
    logic capture;
    logic pop;
    logic clr;
    logic useLatched;
  } seqStrobe_t;

  // conditions reported back by the datapath
  typedef struct packed {
    logic noSel;
    logic needPush;
    logic lastLine;
    logic pendLast;
  } seqStatus_t;

endpackage

// File: rtl/mnt_tag_hit.sv
module mnt_tag_hit #(
  parameter int WAYS  = 4,
  parameter int TAG_W = 22
) (
  input  logic                  enable,
  input  logic                  matchAll,
  input  logic [TAG_W-1:0]      lookTag,
  input  logic [WAYS*TAG_W-1:0] wayTags,
  input  logic [WAYS-1:0]       wayValid,
  output logic [WAYS-1:0]       hit
);

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    logic tagEq;
    assign tagEq  = (wayTags[w*TAG_W +: TAG_W] == lookTag);
    assign hit[w] = enable & wayValid[w] & (matchAll | tagEq);
  end

endmodule

// File: rtl/mnt_datapath.sv
module mnt_datapath
  import mnt_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int SETS   = 64,
  parameter int WAYS   = 4
) (
  input  logic                clk,
  input  logic                rstN,
  input  seqStrobe_t          stb,
  output seqStatus_t          status,
  input  logic [CMD_W-1:0]    cmdWord,
  input  logic [ADDR_W-1:0]   baseAddr,
  input  logic                page8k,
  output logic [$clog2(SETS)-1:0] lkIdx,
  input  logic [WAYS*(ADDR_W-$clog2(SETS)-4)-1:0] dTags,
  input  logic [WAYS-1:0]     dValid,
  input  logic [WAYS*LINE_WORDS-1:0] dDirty,
  output logic [((WAYS > 1) ? $clog2(WAYS) : 1)-1:0] dRdWay,
  output logic [1:0]          dRdWord,
  input  logic [31:0]         dRdData,
  input  logic [WAYS*(ADDR_W-$clog2(SETS)-4)-1:0] iTags,
  input  logic [WAYS-1:0]     iValid,
  output logic [WAYS-1:0]     dClrWays,
  output logic [WAYS-1:0]     iClrWays,
  output logic [ADDR_W-1:0]   wbAddr,
  output logic [31:0]         wbData
);

  localparam int IDX_W     = $clog2(SETS);
  localparam int TAG_W     = ADDR_W - IDX_W - 4;
  localparam int PEND_W    = WAYS * LINE_WORDS;
  localparam int PICK_W    = $clog2(PEND_W);
  localparam int WAY_W     = (WAYS > 1) ? $clog2(WAYS) : 1;
  localparam int MAX_LINES = (SETS > 512) ? SETS : 512;
  localparam int CNT_W     = $clog2(MAX_LINES) + 1;

  logic [ADDR_W-1:0] curAddr;
  logic [CNT_W-1:0]  linesLeft;
  logic              selDQ, selIQ, allQ, pushQ;
  logic [PEND_W-1:0] pendQ;
  logic [WAYS-1:0]   hitDQ, hitIQ;

  logic [ADDR_W-1:0] alignAddr;
  logic [CNT_W-1:0]  lineCnt;
  scope_t            scope;
  logic              unusedCmdBits;

  assign scope         = scope_t'(cmdWord[SCOPE_LO +: 2]);
  assign unusedCmdBits = ^cmdWord[SCOPE_LO-1:0];

  // range of the incoming command
  always_comb begin
    case (scope)
      SCOPE_ALL: begin
        alignAddr = '0;
        lineCnt   = CNT_W'(SETS);
      end
      SCOPE_PAGE: begin
        if (page8k) begin
          alignAddr = baseAddr & ~(ADDR_W'(8191));
          lineCnt   = CNT_W'(512);
        end else begin
          alignAddr = baseAddr & ~(ADDR_W'(4095));
          lineCnt   = CNT_W'(256);
        end
      end
      default: begin
        alignAddr = baseAddr & ~(ADDR_W'(15));
        lineCnt   = CNT_W'(1);
      end
    endcase
  end

  // lookup of the current line
  logic [TAG_W-1:0]  lookTag;
  logic [WAYS-1:0]   hitD, hitI;
  logic [PEND_W-1:0] dirtyHit;

  assign lkIdx   = curAddr[IDX_W+3:4];
  assign lookTag = curAddr[ADDR_W-1:IDX_W+4];

  mnt_tag_hit #(.WAYS(WAYS), .TAG_W(TAG_W)) u_hitD (
    .enable(selDQ), .matchAll(allQ), .lookTag(lookTag),
    .wayTags(dTags), .wayValid(dValid), .hit(hitD)
  );

  mnt_tag_hit #(.WAYS(WAYS), .TAG_W(TAG_W)) u_hitI (
    .enable(selIQ), .matchAll(allQ), .lookTag(lookTag),
    .wayTags(iTags), .wayValid(iValid), .hit(hitI)
  );

  for (genvar w = 0; w < WAYS; w++) begin : g_dirty
    for (genvar k = 0; k < LINE_WORDS; k++) begin : g_word
      assign dirtyHit[w*LINE_WORDS+k] = dDirty[w*LINE_WORDS+k] & hitD[w];
    end
  end

  // lowest pending longword goes out first
  logic [PICK_W-1:0] pick;
  always_comb begin
    pick = '0;
    for (int i = PEND_W - 1; i >= 0; i--) begin
      if (pendQ[i]) pick = PICK_W'(i);
    end
  end

  logic [TAG_W-1:0] pushTag;
  assign dRdWay  = WAY_W'(pick >> 2);
  assign dRdWord = pick[1:0];
  assign pushTag = dTags[dRdWay*TAG_W +: TAG_W];
  assign wbAddr  = {pushTag, lkIdx, dRdWord, 2'b00};
  assign wbData  = dRdData;

  assign dClrWays = stb.clr ? (stb.useLatched ? hitDQ : hitD) : '0;
  assign iClrWays = stb.clr ? (stb.useLatched ? hitIQ : hitI) : '0;

  assign status.noSel    = ~(cmdWord[SEL_D_BIT] | cmdWord[SEL_I_BIT]);
  assign status.needPush = pushQ & (|dirtyHit);
  assign status.lastLine = (linesLeft == CNT_W'(1));
  assign status.pendLast = (pendQ != '0) && ((pendQ & (pendQ - PEND_W'(1))) == '0);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      curAddr   <= '0;
      linesLeft <= '0;
      selDQ     <= 1'b0;
      selIQ     <= 1'b0;
      allQ      <= 1'b0;
      pushQ     <= 1'b0;
    end else if (stb.load) begin
      curAddr   <= alignAddr;
      linesLeft <= lineCnt;
      selDQ     <= cmdWord[SEL_D_BIT];
      selIQ     <= cmdWord[SEL_I_BIT];
      allQ      <= (scope == SCOPE_ALL);
      pushQ     <= cmdWord[PUSH_BIT];
    end else if (stb.advance) begin
      curAddr   <= curAddr + ADDR_W'(16);
      linesLeft <= linesLeft - CNT_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pendQ <= '0;
      hitDQ <= '0;
      hitIQ <= '0;
    end else if (stb.capture) begin
      pendQ <= dirtyHit;
      hitDQ <= hitD;
      hitIQ <= hitI;
    end else if (stb.pop) begin
      pendQ <= pendQ & ~(PEND_W'(1) << pick);
    end
  end

endmodule

// File: rtl/mnt_ctrl.sv
module mnt_ctrl
  import mnt_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       cmdValid,
  input  logic       wbReady,
  input  seqStatus_t status,
  output seqStrobe_t stb,
  output logic       cmdReady,
  output logic       wbValid,
  output logic       done,
  output logic       lineBufInval
);

  seqState_t state, nextState;
  logic      finish;
  logic      doneQ, lbiQ;

  assign cmdReady     = (state == ST_IDLE) && !doneQ;
  assign done         = doneQ;
  assign lineBufInval = lbiQ;

  always_comb begin
    stb       = '0;
    nextState = state;
    finish    = 1'b0;
    wbValid   = 1'b0;
    case (state)
      ST_IDLE: begin
        if (cmdValid && cmdReady) begin
          stb.load = 1'b1;
          if (status.noSel) finish = 1'b1;
          else              nextState = ST_LOOK;
        end
      end
      ST_LOOK: begin
        if (status.needPush) begin
          stb.capture = 1'b1;
          nextState   = ST_PUSH;
        end else begin
          stb.clr     = 1'b1;
          stb.advance = 1'b1;
          if (status.lastLine) begin
            finish    = 1'b1;
            nextState = ST_IDLE;
          end
        end
      end
      ST_PUSH: begin
        wbValid = 1'b1;
        if (wbReady) begin
          stb.pop = 1'b1;
          if (status.pendLast) begin
            stb.clr        = 1'b1;
            stb.useLatched = 1'b1;
            stb.advance    = 1'b1;
            if (status.lastLine) begin
              finish    = 1'b1;
              nextState = ST_IDLE;
            end else begin
              nextState = ST_LOOK;
            end
          end
        end
      end
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_IDLE;
      doneQ <= 1'b0;
      lbiQ  <= 1'b0;
    end else begin
      state <= nextState;
      doneQ <= finish;
      lbiQ  <= stb.load;
    end
  end

endmodule

// File: rtl/cache_maint_seq.sv
module cache_maint_seq
  import mnt_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int SETS   = 64,
  parameter int WAYS   = 4
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                cmdValid,
  output logic                cmdReady,
  input  logic [7:0]          cmdWord,
  input  logic [ADDR_W-1:0]   baseAddr,
  input  logic                page8k,
  output logic [$clog2(SETS)-1:0] lkIdx,
  input  logic [WAYS*(ADDR_W-$clog2(SETS)-4)-1:0] dTags,
  input  logic [WAYS-1:0]     dValid,
  input  logic [WAYS*4-1:0]   dDirty,
  output logic [((WAYS > 1) ? $clog2(WAYS) : 1)-1:0] dRdWay,
  output logic [1:0]          dRdWord,
  input  logic [31:0]         dRdData,
  input  logic [WAYS*(ADDR_W-$clog2(SETS)-4)-1:0] iTags,
  input  logic [WAYS-1:0]     iValid,
  output logic                clrEn,
  output logic [WAYS-1:0]     dClrWays,
  output logic [WAYS-1:0]     iClrWays,
  output logic                wbValid,
  input  logic                wbReady,
  output logic [ADDR_W-1:0]   wbAddr,
  output logic [31:0]         wbData,
  output logic                lineBufInval,
  output logic                done
);

  seqStrobe_t stb;
  seqStatus_t status;

  assign clrEn = stb.clr;

  mnt_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .wbReady(wbReady),
    .status(status), .stb(stb), .cmdReady(cmdReady), .wbValid(wbValid),
    .done(done), .lineBufInval(lineBufInval)
  );

  mnt_datapath #(.ADDR_W(ADDR_W), .SETS(SETS), .WAYS(WAYS)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .status(status),
    .cmdWord(cmdWord), .baseAddr(baseAddr), .page8k(page8k),
    .lkIdx(lkIdx), .dTags(dTags), .dValid(dValid), .dDirty(dDirty),
    .dRdWay(dRdWay), .dRdWord(dRdWord), .dRdData(dRdData),
    .iTags(iTags), .iValid(iValid),
    .dClrWays(dClrWays), .iClrWays(iClrWays),
    .wbAddr(wbAddr), .wbData(wbData)
  );

endmodule

// File: rtl/cache_maint_seq_checker.sv
module cache_maint_seq_checker #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              cmdValid,
  input logic              cmdReady,
  input logic [7:0]        cmdWord,
  input logic              clrEn,
  input logic              wbValid,
  input logic              wbReady,
  input logic [ADDR_W-1:0] wbAddr,
  input logic [31:0]       wbData,
  input logic              lineBufInval,
  input logic              done
);

  logic pushSeen;
  always_ff @(posedge clk) begin
    if (!rstN)                      pushSeen <= 1'b0;
    else if (cmdValid && cmdReady)  pushSeen <= cmdWord[5];
  end

  AST_IDLE_SILENT: assert property (@(posedge clk) disable iff (!rstN)
    cmdReady |-> (!wbValid && !clrEn)); // R1

  AST_LBI_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && cmdReady) |=> lineBufInval); // R1

  AST_NO_PUSH_WITHOUT_FLAG: assert property (@(posedge clk) disable iff (!rstN)
    wbValid |-> pushSeen); // R7

  AST_WB_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (wbValid && !wbReady) |=> (wbValid && $stable(wbAddr) && $stable(wbData))); // R8

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done); // R9

  AST_DONE_NOT_READY: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !cmdReady); // R9

endmodule

bind cache_maint_seq cache_maint_seq_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdReady(cmdReady),
  .cmdWord(cmdWord), .clrEn(clrEn), .wbValid(wbValid), .wbReady(wbReady),
  .wbAddr(wbAddr), .wbData(wbData), .lineBufInval(lineBufInval), .done(done)
);

// File: tb/sim_cache_maint_seq.sv
`timescale 1ns/1ps
module sim_cache_maint_seq;

  localparam int ADDR_W = 32;
  localparam int SETS   = 16;
  localparam int WAYS   = 2;
  localparam int IDX_W  = 4;
  localparam int TAG_W  = ADDR_W - IDX_W - 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cmdValid = 1'b0;
  logic cmdReady;
  logic [7:0] cmdWord = '0;
  logic [ADDR_W-1:0] baseAddr = '0;
  logic page8k = 1'b0;
  logic [IDX_W-1:0] lkIdx;
  logic [WAYS*TAG_W-1:0] dTags, iTags;
  logic [WAYS-1:0] dValid, iValid;
  logic [WAYS*4-1:0] dDirty;
  logic [0:0] dRdWay;
  logic [1:0] dRdWord;
  logic [31:0] dRdData;
  logic clrEn;
  logic [WAYS-1:0] dClrWays, iClrWays;
  logic wbValid;
  logic wbReady = 1'b1;
  logic [ADDR_W-1:0] wbAddr;
  logic [31:0] wbData;
  logic lineBufInval, done;

  int checks = 0;
  int errors = 0;
  logic stall = 1'b0;

  always #2 clk = ~clk;

  cache_maint_seq #(.ADDR_W(ADDR_W), .SETS(SETS), .WAYS(WAYS)) u0 (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdReady(cmdReady),
    .cmdWord(cmdWord), .baseAddr(baseAddr), .page8k(page8k), .lkIdx(lkIdx),
    .dTags(dTags), .dValid(dValid), .dDirty(dDirty), .dRdWay(dRdWay),
    .dRdWord(dRdWord), .dRdData(dRdData), .iTags(iTags), .iValid(iValid),
    .clrEn(clrEn), .dClrWays(dClrWays), .iClrWays(iClrWays),
    .wbValid(wbValid), .wbReady(wbReady), .wbAddr(wbAddr), .wbData(wbData),
    .lineBufInval(lineBufInval), .done(done)
  );

  // cache array models
  logic [TAG_W-1:0] dTagA [SETS][WAYS];
  logic             dValA [SETS][WAYS];
  logic [3:0]       dDirA [SETS][WAYS];
  logic [TAG_W-1:0] iTagA [SETS][WAYS];
  logic             iValA [SETS][WAYS];

  function automatic logic [31:0] datVal(int s, int w, int k);
    return 32'hD000_0000 | (s << 8) | (w << 4) | k;
  endfunction

  always_comb begin
    for (int w = 0; w < WAYS; w++) begin
      dTags[w*TAG_W +: TAG_W] = dTagA[lkIdx][w];
      dValid[w]               = dValA[lkIdx][w];
      dDirty[w*4 +: 4]        = dDirA[lkIdx][w];
      iTags[w*TAG_W +: TAG_W] = iTagA[lkIdx][w];
      iValid[w]               = iValA[lkIdx][w];
    end
    dRdData = datVal(int'(lkIdx), int'(dRdWay), int'(dRdWord));
  end

  always @(posedge clk) begin
    if (clrEn) begin
      for (int w = 0; w < WAYS; w++) begin
        if (dClrWays[w]) begin
          dValA[lkIdx][w] <= 1'b0;
          dDirA[lkIdx][w] <= 4'h0;
        end
        if (iClrWays[w]) iValA[lkIdx][w] <= 1'b0;
      end
    end
  end

  // write-back memory log
  logic [31:0] wbLogA [64];
  logic [31:0] wbLogD [64];
  int wbN = 0;
  always @(posedge clk) begin
    if (wbValid && wbReady) begin
      if (wbN < 64) begin
        wbLogA[wbN] <= wbAddr;
        wbLogD[wbN] <= wbData;
      end
      wbN <= wbN + 1;
    end
  end

  always @(negedge clk) wbReady <= stall ? ~wbReady : 1'b1;

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wipe();
    for (int s = 0; s < SETS; s++)
      for (int w = 0; w < WAYS; w++) begin
        dTagA[s][w] = '0; dValA[s][w] = 1'b0; dDirA[s][w] = 4'h0;
        iTagA[s][w] = '0; iValA[s][w] = 1'b0;
      end
  endtask

  task automatic putD(int s, int w, logic [TAG_W-1:0] t, logic [3:0] d);
    dTagA[s][w] = t; dValA[s][w] = 1'b1; dDirA[s][w] = d;
  endtask

  task automatic putI(int s, int w, logic [TAG_W-1:0] t);
    iTagA[s][w] = t; iValA[s][w] = 1'b1;
  endtask

  // issue one command and wait for done; cycles counts from acceptance
  task automatic runCmd(logic [7:0] cmd, logic [31:0] base, logic p8k, output int cycles);
    @(negedge clk);
    cmdWord = cmd; baseAddr = base; page8k = p8k; cmdValid = 1'b1;
    while (!cmdReady) @(negedge clk);
    @(negedge clk);
    cmdValid = 1'b0;
    chk("R1 lineBufInval after accept", lineBufInval, 1'b1);
    cycles = 1;
    while (!done && cycles < 5000) begin
      @(negedge clk);
      cycles++;
    end
    if (cycles >= 5000) chk("R9 done watchdog", 0, 1);
    @(negedge clk);
    chk("R9 done single pulse", done, 1'b0);
  endtask

  task automatic testReset();
    chk("R1 ready after reset", cmdReady, 1'b1);
    chk("R9 done low after reset", done, 1'b0);
    chk("R8 no write-back after reset", wbValid, 1'b0);
    chk("R1 no line buffer strobe after reset", lineBufInval, 1'b0);
  endtask

  task automatic testLineDiscard();
    int cyc; int n0;
    wipe();
    putD(7, 0, 24'h123456, 4'hF);
    putD(7, 1, 24'h654321, 4'h3);
    putI(7, 0, 24'h123456);
    n0 = wbN;
    runCmd(8'h48, 32'h1234_567B, 1'b0, cyc);
    chk("R3 line scope cycles", cyc, 2);
    chk("R6 matching way invalidated", dValA[7][0], 1'b0);
    chk("R7 dirty cleared without push", dDirA[7][0], 4'h0);
    chk("R6 other way kept", dValA[7][1], 1'b1);
    chk("R6 other way dirty kept", dDirA[7][1], 4'h3);
    chk("R7 no write-back", wbN - n0, 0);
    chk("R2 instruction cache not selected", iValA[7][0], 1'b1);
  endtask

  task automatic testLinePush();
    int cyc; int n0;
    wipe();
    putD(7, 1, 24'h123456, 4'b1010);
    putI(7, 1, 24'h123456);
    n0 = wbN;
    stall = 1'b1;
    runCmd(8'hE8, 32'h1234_5670, 1'b0, cyc);
    stall = 1'b0;
    chk("R8 push count", wbN - n0, 2);
    chk("R8 first push address", wbLogA[n0], 32'h1234_5674);
    chk("R8 first push data", wbLogD[n0], datVal(7, 1, 1));
    chk("R8 second push address", wbLogA[n0+1], 32'h1234_567C);
    chk("R8 second push data", wbLogD[n0+1], datVal(7, 1, 3));
    chk("R8 pushed line invalid", dValA[7][1], 1'b0);
    chk("R8 pushed line clean", dDirA[7][1], 4'h0);
    chk("R10 instruction line invalidated", iValA[7][1], 1'b0);
  endtask

  task automatic testPushTiming();
    int cyc; int n0;
    wipe();
    putD(2, 0, 24'h00ABCD, 4'b0011);
    n0 = wbN;
    runCmd(8'h68, 32'h00AB_CD20, 1'b0, cyc);
    chk("R8 one cycle per pushed longword", cyc, 4);
    chk("R8 ordered low word first", wbLogA[n0], 32'h00AB_CD20);
  endtask

  task automatic testInstrOnly();
    int cyc; int n0;
    wipe();
    putD(3, 0, 24'h000AAA, 4'hF);
    putI(3, 0, 24'h000AAA);
    putI(3, 1, 24'h000BBB);
    n0 = wbN;
    runCmd(8'hA8, 32'h000A_AA30, 1'b0, cyc);
    chk("R2 data cache untouched", dValA[3][0], 1'b1);
    chk("R10 no push from instruction cache", wbN - n0, 0);
    chk("R2 instruction match cleared", iValA[3][0], 1'b0);
    chk("R6 instruction miss kept", iValA[3][1], 1'b1);
  endtask

  task automatic testScopeZero();
    int cyc;
    wipe();
    putD(4, 0, 24'h000777, 4'h0);
    putD(5, 0, 24'h000777, 4'h0);
    runCmd(8'h40, 32'h0007_774C, 1'b0, cyc);
    chk("R3 scope zero acts as line", dValA[4][0], 1'b0);
    chk("R3 scope zero neighbour kept", dValA[5][0], 1'b1);
    chk("R3 scope zero cycles", cyc, 2);
  endtask

  task automatic testNoSelect();
    int cyc; int n0;
    wipe();
    putD(1, 0, 24'h000001, 4'hF);
    putI(1, 0, 24'h000001);
    n0 = wbN;
    runCmd(8'h38, 32'h0000_0110, 1'b0, cyc);
    chk("R2 no cache selected done next cycle", cyc, 1);
    chk("R2 data line kept", dValA[1][0], 1'b1);
    chk("R2 instruction line kept", iValA[1][0], 1'b1);
    chk("R2 no write-back", wbN - n0, 0);
  endtask

  task automatic testPage4k();
    int cyc;
    wipe();
    putD(3, 0, 24'h000025, 4'h0);
    putD(3, 1, 24'h000035, 4'h0);
    putD(15, 0, 24'h00002F, 4'h0);
    putD(0, 1, 24'h00001F, 4'h0);
    putI(3, 0, 24'h000025);
    runCmd(8'h50, 32'h0000_2345, 1'b0, cyc);
    chk("R4 4K page cycles", cyc, 257);
    chk("R4 line inside page cleared", dValA[3][0], 1'b0);
    chk("R4 last line of page cleared", dValA[15][0], 1'b0);
    chk("R6 line above page kept", dValA[3][1], 1'b1);
    chk("R6 line below page kept", dValA[0][1], 1'b1);
    chk("R2 instruction cache kept in page sweep", iValA[3][0], 1'b1);
  endtask

  task automatic testPage8k();
    int cyc;
    wipe();
    putD(3, 1, 24'h000035, 4'h0);
    putD(3, 0, 24'h000045, 4'h0);
    putD(8, 0, 24'h000020, 4'h0);
    runCmd(8'h50, 32'h0000_3000, 1'b1, cyc);
    chk("R4 8K page cycles", cyc, 513);
    chk("R4 upper half of 8K page cleared", dValA[3][1], 1'b0);
    chk("R4 lower half of 8K page cleared", dValA[8][0], 1'b0);
    chk("R6 line past 8K page kept", dValA[3][0], 1'b1);
  endtask

  task automatic testAllPush();
    int cyc; int n0; int left;
    wipe();
    putD(5, 1, 24'hABCDEF, 4'b0001);
    putD(9, 0, 24'h000111, 4'b1000);
    putD(2, 0, 24'h0F0F0F, 4'b0000);
    putI(12, 1, 24'h333333);
    putI(0, 0, 24'h444444);
    n0 = wbN;
    runCmd(8'hF8, 32'h5555_5555, 1'b0, cyc);
    chk("R5 whole cache cycles", cyc, 19);
    chk("R8 push count whole cache", wbN - n0, 2);
    chk("R8 address from stored tag", wbLogA[n0], 32'hABCD_EF50);
    chk("R8 data from stored line", wbLogD[n0], datVal(5, 1, 0));
    chk("R8 second address by set order", wbLogA[n0+1], 32'h0001_119C);
    left = 0;
    for (int s = 0; s < SETS; s++)
      for (int w = 0; w < WAYS; w++)
        left += int'(dValA[s][w]) + int'(iValA[s][w]);
    chk("R5 every line invalidated", left, 0);
  endtask

  task automatic testBusyIgnored();
    int cyc;
    wipe();
    putD(4, 0, 24'h000077, 4'h0);
    putD(6, 0, 24'h000020, 4'h0);
    @(negedge clk);
    cmdWord = 8'h50; baseAddr = 32'h0000_2000; page8k = 1'b0; cmdValid = 1'b1;
    while (!cmdReady) @(negedge clk);
    @(negedge clk);
    cmdValid = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 not ready while sweeping", cmdReady, 1'b0);
    cmdWord = 8'h58; cmdValid = 1'b1;
    repeat (4) @(negedge clk);
    cmdValid = 1'b0;
    cyc = 0;
    while (!done && cyc < 5000) begin
      @(negedge clk);
      cyc++;
    end
    @(negedge clk);
    chk("R1 command during sweep ignored", dValA[4][0], 1'b1);
    chk("R4 page line cleared in busy test", dValA[6][0], 1'b0);
    chk("R1 idle after sweep", cmdReady, 1'b1);
  endtask

  initial begin
    wipe();
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testLineDiscard();
    testLinePush();
    testPushTiming();
    testInstrOnly();
    testScopeZero();
    testNoSelect();
    testPage4k();
    testPage8k();
    testAllPush();
    testBusyIgnored();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule